// File: doc/BRIEF.md
# Thermal Trip Latch Controller

This block converts a raw over-temperature comparator bit into a sticky, active-low thermal-trip indication that is qualified by a power-good input. The comparator bit is treated as asynchronous and is passed through a two-stage synchronizer. The power-good input is treated as synchronous to the block clock.

After power-good rises, an arming timer counts a fixed number of clock cycles. Until that count completes, the trip output stays inactive whatever the sensor reports. Once armed, a single synchronized cycle of over-temperature sets the trip latch. The trip output then goes low and a clock-stop command goes high, and both hold until power-good falls. Loss of power-good clears everything at once and resets the arming timer. If the sensor is still hot when power-good returns, the trip reasserts on the first cycle after the arming window.

The arming delay is a parameter in clock cycles. It must not exceed 10 microseconds at the configured clock frequency.

Top module: `thermtrip_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, trip_n is 1, clk_stop is 0 and armed is 0.
- R2: armed goes high after the ARM_DELAY-th rising clock edge at which pwr_good is sampled high continuously. It is low before that edge and stays high while pwr_good stays high.
- R3: While armed is low, trip_n stays 1 regardless of over_temp, and over-temperature seen only before arming does not trip the block later.
- R4: over_temp passes two synchronizer flops. If over_temp is sampled high at edge p with pwr_good high since edge 1, the trip latch sets if and only if p >= ARM_DELAY-1. trip_n then goes low after edge p+2.
- R5: Once trip_n is low, it stays low while pwr_good stays high, even after over_temp returns low.
- R6: When pwr_good is low, trip_n is 1, armed is 0 and clk_stop is 0 in that same cycle, with no clock edge needed. The latch is cleared.
- R7: clk_stop is always the complement of trip_n.
- R8: With over_temp held high through a pwr_good return, trip_n stays 1 through edge ARM_DELAY and goes low after edge ARM_DELAY+1.
- R9: ARM_DELAY is at least 1 and no larger than CLK_MHZ*10 cycles (10 microseconds).
- R10: An over_temp pulse only one clock wide while armed is enough to set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good qualifier, synchronous to clk |
| over_temp | input | 1 | Raw over-temperature comparator bit, asynchronous |
| trip_n | output | 1 | Thermal trip, active low, latched |
| clk_stop | output | 1 | Core clock shutdown command while tripped |
| armed | output | 1 | High once the arming delay has elapsed under power-good |

## Verification
The arming timer expiring and the synchronized over-temperature bit becoming valid can fall on the same clock cycle. Whether the latch sets there decides if a trip is caught at the very edge of the window. The bench sweeps a one-cycle raw pulse across every position from the first power-good edge to past the arming point, including the positions where the synchronized pulse lands exactly on the arming cycle. It then holds the sensor hot through a power-good return so that arming and detection coincide. Each case is judged against the arithmetic rule that a trip occurs only for p >= ARM_DELAY-1, appearing after edge p+2, and after edge ARM_DELAY+1 for a held input.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    // Latch state of the trip detector
    typedef enum logic {
        TL_CLEAR   = 1'b0,
        TL_TRIPPED = 1'b1
    } trip_state_e;

    // Output-facing status bundle
    typedef struct packed {
        logic trip_act;
        logic armed;
    } trip_status_t;

    // Largest legal arming delay in cycles: 10 us at clk_mhz
    function automatic int unsigned arm_limit(input int unsigned clk_mhz);
        return clk_mhz * 10;
    endfunction

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tt_arm_timer.sv
module tt_arm_timer #(
    parameter int unsigned ARM_DELAY = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    output logic ready
);
    localparam int unsigned CW = $clog2(ARM_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(ARM_DELAY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == LIMIT);
endmodule

// File: rtl/tt_trip_latch.sv
module tt_trip_latch
    import thermtrip_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_good,
    input  logic        arm_ok,
    input  logic        hot,
    output trip_state_e state
);
    trip_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (!pwr_good) begin
            state_nx = TL_CLEAR;
        end else if (arm_ok && hot) begin
            state_nx = TL_TRIPPED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TL_CLEAR;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/thermtrip_ctrl.sv
module thermtrip_ctrl
    import thermtrip_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned ARM_DELAY   = 2000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic over_temp,
    output logic trip_n,
    output logic clk_stop,
    output logic armed
);
    logic         hot_s;
    logic         timer_ready;
    trip_state_e  latch_q;
    trip_status_t status;

    tt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (over_temp),
        .q_sync  (hot_s)
    );

    tt_arm_timer #(.ARM_DELAY(ARM_DELAY)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .ready    (timer_ready)
    );

    tt_trip_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .arm_ok   (timer_ready),
        .hot      (hot_s),
        .state    (latch_q)
    );

    // Power-good gates the outputs directly so loss releases them at once
    always_comb begin
        status.armed    = pwr_good && timer_ready;
        status.trip_act = pwr_good && (latch_q == TL_TRIPPED);
    end

    assign trip_n   = ~status.trip_act;
    assign clk_stop = status.trip_act;
    assign armed    = status.armed;
endmodule

// File: rtl/thermtrip_chk.sv
module thermtrip_chk #(
    parameter int unsigned CLK_MHZ   = 200,
    parameter int unsigned ARM_DELAY = 2000
) (
    input logic clk,
    input logic rst,
    input logic pwr_good,
    input logic over_temp,
    input logic trip_n,
    input logic clk_stop,
    input logic armed
);
    int unsigned pg_run;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            pg_run <= 0;
        end else if (pg_run < ARM_DELAY) begin
            pg_run <= pg_run + 1;
        end
    end

    initial begin
        assert_delay_range_R9: assert (ARM_DELAY >= 1 && ARM_DELAY <= thermtrip_pkg::arm_limit(CLK_MHZ))
            else $error("ARM_DELAY out of range");
    end

    assert_arm_timing_R2: assert property (@(posedge clk) disable iff (rst)
        armed == (pwr_good && pg_run == ARM_DELAY));

    assert_quiet_unarmed_R3: assert property (@(posedge clk) disable iff (rst)
        !armed |-> trip_n);

    assert_trip_needs_arm_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(trip_n) |-> $past(armed) && pwr_good);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (!trip_n && pwr_good) |=> (!trip_n || !pwr_good));

    assert_pg_release_R6: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |-> (trip_n && !armed && !clk_stop));

    assert_clkstop_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        clk_stop == !trip_n);
endmodule

bind thermtrip_ctrl thermtrip_chk #(.CLK_MHZ(CLK_MHZ), .ARM_DELAY(ARM_DELAY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .over_temp (over_temp),
    .trip_n    (trip_n),
    .clk_stop  (clk_stop),
    .armed     (armed)
);

// File: tb/tb_thermtrip_ctrl.sv
`timescale 1ns/1ps
module tb_thermtrip_ctrl;
    localparam int D = 5;

    logic clk = 1'b0;
    logic rst, pwr_good, over_temp;
    logic trip_n, clk_stop, armed;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    always #2.5 clk = ~clk;

    thermtrip_ctrl #(.CLK_MHZ(200), .ARM_DELAY(D)) dut (
        .clk       (clk),
        .rst       (rst),
        .pwr_good  (pwr_good),
        .over_temp (over_temp),
        .trip_n    (trip_n),
        .clk_stop  (clk_stop),
        .armed     (armed)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic exp_trip_n, input logic exp_armed);
        chk({req, " trip_n"}, trip_n, exp_trip_n);
        chk({req, " armed"}, armed, exp_armed);
        chk("R7 clk_stop", clk_stop, ~exp_trip_n);
    endtask

    task automatic power_down(input int cycles);
        pwr_good  = 1'b0;
        over_temp = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; pwr_good = 1'b0; over_temp = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 1'b1, 1'b0);
        pwr_good = 1'b1; over_temp = 1'b1;
        @(negedge clk);
        chk_all("R1 reset held", 1'b1, 1'b0);
        rst = 1'b0; pwr_good = 1'b0; over_temp = 1'b0;
        @(negedge clk);
        chk_all("R1 after reset", 1'b1, 1'b0);

        // Sweep a one-cycle raw pulse across the arming point (R2, R3, R4, R10, R5)
        for (int p = 1; p <= D + 3; p++) begin
            power_down(4);
            pwr_good  = 1'b1;
            over_temp = (p == 1);
            for (int i = 1; i <= D + 6; i++) begin
                @(negedge clk);
                chk_all((p >= D - 1) ? "R4 R10 R5 pulse" : "R3 R2 early pulse",
                        !((p >= D - 1) && (i >= p + 2)), (i >= D));
                over_temp = (i + 1 == p);
            end
            // R6: release is immediate when power-good drops
            pwr_good = 1'b0;
            #1;
            chk_all("R6 pg drop", 1'b1, 1'b0);
        end

        // R8: sensor held hot across a power-good return
        power_down(2);
        over_temp = 1'b1;
        repeat (3) @(negedge clk);
        chk_all("R6 hot unpowered", 1'b1, 1'b0);
        pwr_good = 1'b1;
        for (int i = 1; i <= D + 3; i++) begin
            @(negedge clk);
            chk_all("R8 hot return", !(i >= D + 1), (i >= D));
        end
        // R5: cooling does not release the trip
        over_temp = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk_all("R5 sticky cooled", 1'b0, 1'b1);
        end
        // R6: loss of power-good clears the latch; repower with cool sensor
        power_down(3);
        pwr_good = 1'b1;
        for (int i = 1; i <= D + 4; i++) begin
            @(negedge clk);
            chk_all("R6 cleared after repower", 1'b1, (i >= D));
        end
        // R2: a power-good glitch restarts the arming count
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        for (int i = 1; i <= D + 1; i++) begin
            @(negedge clk);
            chk_all("R2 rearm count", 1'b1, (i >= D));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule